// File: doc/BRIEF.md
# I2C Register-Write Slave Front End

This block sits behind a pair of bus pins and turns I2C write frames from a bus master into single-cycle write strobes for an internal register file. SCL and SDA are brought into the system clock domain through synchronizer chains, and START, repeated START and STOP are recognised as SDA edges while SCL is high. The first byte of a frame is compared with a 7-bit device address built from a fixed five-bit prefix and two strap pins. The second byte is a register pointer that the surrounding logic must judge. Every later byte is a data byte that is written at the pointer, and the pointer then advances.

The pointer is shown on `wr_addr` as soon as the master has shifted in its eighth bit. The register file answers with `reg_valid_i`, and the slave samples that answer on the SCL falling edge that opens the acknowledge slot. A frame whose read bit is set is acknowledged and flagged on `rd_req`, but the slave drives no read data. The slave never drives SDA high. `sda_oe` is an open-drain pull-down enable.

The controller has seven states. `ST_IDLE` ignores the bus. `ST_DEV` shifts in the device byte. On a match it goes to `ST_DEV_ACK`; on a mismatch it goes back to `ST_IDLE`. `ST_DEV_ACK` goes on to `ST_REG` for a write, or to `ST_IDLE` after acknowledging a read. `ST_REG` shifts in the pointer. It goes to `ST_REG_ACK` when the pointer is valid and to `ST_IDLE` when it is not. `ST_REG_ACK` leads to `ST_DATA`. `ST_DATA` leads to `ST_DATA_ACK` and strobes the write. `ST_DATA_ACK` returns to `ST_DATA` for the next burst byte. Every state change other than a START or STOP happens on an SCL falling edge. A START in any state goes to `ST_DEV`. A STOP in any state goes to `ST_IDLE`.

Top module: `i2c_regwr_slave`

## Requirements
- R1: After reset `sda_oe`, `wr_stb` and `rd_req` are all low, and the slave is idle.
- R2: A frame whose first byte carries bits 7..1 equal to 0,1,0,1,1,`strap_a1`,`strap_a0` (MSB first) and bit 0 = 0 (write) is acknowledged: SDA is held low during the ninth SCL high period.
- R3: A first byte with any other 7-bit address gets no acknowledge, and no byte of that frame acknowledges or strobes until the next START.
- R4: After the eighth bit of the register byte, `wr_addr` shows that byte. If `reg_valid_i` is low at the following SCL fall, the byte is not acknowledged, and later data bytes of the frame are neither acknowledged nor written.
- R5: With a valid register byte, each data byte is acknowledged. The byte also produces exactly one `wr_stb` pulse of one system clock, during which `wr_addr` equals the register byte and `wr_data` equals the data byte.
- R6: In a burst, the k-th data byte (k from 0) is written to the register byte plus k, modulo 256, and each byte is acknowledged.
- R7: A matching first byte with bit 0 = 1 (read) is acknowledged and pulses `rd_req` for one system clock. SDA is not driven for the rest of the frame, and nothing is written.
- R8: A repeated START, even in the middle of a data byte, drops the partial byte without a write and starts a new device-address phase.
- R9: After a STOP, bytes clocked on the bus without a new START are neither acknowledged nor written.
- R10: `sda_oe` changes only while the synchronized SCL is low, and is released in the cycle after a STOP is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_a1 | input | 1 | Upper strap bit of the device address |
| strap_a0 | input | 1 | Lower strap bit of the device address |
| reg_valid_i | input | 1 | High when `wr_addr` names an existing register |
| sda_oe | output | 1 | Pull SDA low when high (open-drain enable) |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register pointer |
| wr_data | output | 8 | Data byte for the write strobe |
| rd_req | output | 1 | One-cycle pulse when a read frame is acknowledged |

## Verification
The bench builds the block with its default prefix 01011 and a two-stage synchronizer, and it models the open-drain bus as the master's level ANDed with the inverted `sda_oe`. With only seven address bits and two straps, it can sweep every device address under one strap setting, and then every pairing of strap setting and strap-field value. A register map that rejects 0xA0..0xBF lets a stride sweep over the pointer hit both accepted and refused bytes. A burst starting at 0xFD crosses the 8-bit wrap.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_DATA,
        ST_DATA_ACK
    } bus_state_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              sda_s;

    // The bus idles high, so the chains reset to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic [BITS-1:0] byte_o,
    output logic            full,
    output logic            done
);
    localparam int CW = $clog2(BITS + 1);

    logic [CW-1:0] cnt;

    assign full = (cnt == CW'(BITS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            byte_o <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clr) begin
                cnt <= '0;
            end else if (shift_en && !full) begin
                byte_o <= {byte_o[BITS-2:0], bit_in};
                cnt    <= cnt + 1'b1;
                done   <= (cnt == CW'(BITS - 1));
            end
        end
    end
endmodule

// File: rtl/i2c_regwr_slave.sv
module i2c_regwr_slave
    import i2c_regwr_pkg::*;
#(
    parameter logic [4:0] DEV_PREFIX  = 5'b01011,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              strap_a1,
    input  logic              strap_a0,
    input  logic              reg_valid_i,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_req
);
    bus_state_t        state;
    bus_state_t        nxt;
    logic              scl_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_full;
    logic              rx_done;
    logic              rx_clr;
    logic              rx_shift;
    logic              in_ack;
    logic              dev_hit;
    logic              rw_q;
    logic [BYTE_W-1:0] ptr;
    logic [BYTE_W-1:0] data_q;
    logic              stb_q;
    logic              rd_q;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign in_ack   = (state == ST_DEV_ACK) || (state == ST_REG_ACK) ||
                      (state == ST_DATA_ACK);
    assign rx_shift = scl_rise && ((state == ST_DEV) || (state == ST_REG) ||
                                   (state == ST_DATA));
    assign rx_clr   = start_det || (in_ack && scl_fall);

    i2c_byte_shift #(.BITS(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_clr),
        .shift_en (rx_shift),
        .bit_in   (u_sync.sda_s),
        .byte_o   (rx_byte),
        .full     (rx_full),
        .done     (rx_done)
    );

    assign dev_hit = (rx_byte[BYTE_W-1:1] == {DEV_PREFIX, strap_a1, strap_a0});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state decode; bus conditions override the byte flow
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_DEV;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_DEV:      if (rx_full && scl_fall) nxt = dev_hit ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:  if (scl_fall) nxt = rw_q ? ST_IDLE : ST_REG;
                ST_REG:      if (rx_full && scl_fall) nxt = reg_valid_i ? ST_REG_ACK : ST_IDLE;
                ST_REG_ACK:  if (scl_fall) nxt = ST_DATA;
                ST_DATA:     if (rx_full && scl_fall) nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) nxt = ST_DATA;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rw_q   <= 1'b0;
            ptr    <= '0;
            data_q <= '0;
            stb_q  <= 1'b0;
            rd_q   <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            rd_q  <= 1'b0;
            if (state == ST_DEV && nxt == ST_DEV_ACK) begin
                rw_q <= rx_byte[0];
                rd_q <= rx_byte[0];
            end
            if (state == ST_REG && rx_done) begin
                ptr <= rx_byte;
            end else if (stb_q) begin
                ptr <= ptr + 1'b1;
            end
            if (state == ST_DATA && nxt == ST_DATA_ACK) begin
                stb_q  <= 1'b1;
                data_q <= rx_byte;
            end
        end
    end

    assign sda_oe  = in_ack;
    assign wr_stb  = stb_q;
    assign wr_addr = ptr;
    assign wr_data = data_q;
    assign rd_req  = rd_q;
endmodule

// File: rtl/i2c_regwr_chk.sv
module i2c_regwr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       scl_s,
    input logic       stop_det,
    input logic       wr_stb,
    input logic       rd_req,
    input logic [7:0] wr_addr
);
    // R5
    stb_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R6
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (wr_addr == $past(wr_addr) + 8'd1));

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R7
    rd_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_stb));

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
endmodule

bind i2c_regwr_slave i2c_regwr_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .scl_s    (scl_s),
    .stop_det (stop_det),
    .wr_stb   (wr_stb),
    .rd_req   (rd_req),
    .wr_addr  (wr_addr)
);

// File: tb/i2c_regwr_slave_bench.sv
module i2c_regwr_slave_bench;
    localparam int Q = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       a1 = 1'b1;
    logic       a0 = 1'b0;
    logic       sda_oe, wr_stb, rd_req;
    logic [7:0] wr_addr, wr_data;
    logic       sda_line;
    logic       reg_ok;

    int checks = 0;
    int fails = 0;
    int n_stb = 0;
    int n_rd = 0;
    int n_oe = 0;
    logic [7:0] log_a [0:63];
    logic [7:0] log_d [0:63];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign reg_ok   = (wr_addr[7:5] != 3'b101);

    i2c_regwr_slave u_i2c_regwr_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .strap_a1    (a1),
        .strap_a0    (a0),
        .reg_valid_i (reg_ok),
        .sda_oe      (sda_oe),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_req      (rd_req)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (wr_stb) begin
                log_a[n_stb % 64] <= wr_addr;
                log_d[n_stb % 64] <= wr_data;
                n_stb <= n_stb + 1;
            end
            if (rd_req) n_rd <= n_rd + 1;
            if (sda_oe) n_oe <= n_oe + 1;
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(2 * Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7 - i]; w(Q); scl_m = 1'b1; w(Q); scl_m = 1'b0; w(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q / 2);
        ack = !sda_line;
        w(Q / 2); scl_m = 1'b0; w(2);
    endtask

    function automatic bit valid_reg(input logic [7:0] r);
        return r[7:5] != 3'b101;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        bit ack;
        int exp_n;
        logic [7:0] r;
        w(10);
        // R1 reset state
        chk(!sda_oe && !wr_stb && !rd_req, "R1 reset outputs",
            {sda_oe, wr_stb, rd_req}, 0);
        rst_n = 1'b1;
        w(5);
        chk(!sda_oe && !wr_stb && !rd_req, "R1 idle after reset",
            {sda_oe, wr_stb, rd_req}, 0);

        // R2/R3 sweep over every 7-bit device address, straps = 10
        for (int a = 0; a < 128; a++) begin
            bit exp;
            exp = (a[6:0] == 7'b0101110);
            bus_start(); send_byte({a[6:0], 1'b0}, ack); bus_stop();
            chk(ack == exp, exp ? "R2 match ack" : "R3 mismatch nack", ack, exp);
        end
        chk(n_stb == 0, "R3 no strobe in sweep", n_stb, 0);

        // R2 every strap setting against every strap-field value
        for (int s = 0; s < 4; s++) begin
            {a1, a0} = 2'(s);
            w(4);
            for (int t = 0; t < 4; t++) begin
                bus_start(); send_byte({5'b01011, 2'(t), 1'b0}, ack); bus_stop();
                chk(ack == (t == s), "R2 strap match", ack, t == s);
            end
        end
        {a1, a0} = 2'b10;
        w(4);

        // R4/R5 register pointer stride sweep, single writes
        exp_n = n_stb;
        for (int k = 0; k < 32; k++) begin
            bit v;
            bit ad, ar;
            r = 8'(k * 8 + (k % 8));
            v = valid_reg(r);
            bus_start();
            send_byte(8'h5C, ad);
            send_byte(r, ar);
            chk(ar == v, "R4 reg ack follows valid", ar, v);
            send_byte(r ^ 8'h5A, ack);
            bus_stop();
            chk(ack == v, v ? "R5 data ack" : "R4 data after nack", ack, v);
            if (v) begin
                exp_n++;
                chk(n_stb == exp_n && log_a[(exp_n - 1) % 64] == r &&
                    log_d[(exp_n - 1) % 64] == (r ^ 8'h5A),
                    "R5 single write strobe", log_a[(exp_n - 1) % 64], r);
            end else begin
                chk(n_stb == exp_n, "R4 no write after invalid reg", n_stb, exp_n);
            end
        end

        // R4 pointer visible on wr_addr before ack slot
        bus_start(); send_byte(8'h5C, ack); send_bits(8'h3E, 8); w(6);
        chk(wr_addr == 8'h3E, "R4 pointer shown", wr_addr, 8'h3E);
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); scl_m = 1'b0; w(2);
        bus_stop();

        // R6 burst crossing 8-bit wrap
        exp_n = n_stb;
        bus_start(); send_byte(8'h5C, ack); send_byte(8'hFD, ack);
        for (int i = 0; i < 5; i++) begin
            send_byte(8'h30 + 8'(i), ack);
            chk(ack, "R6 burst byte ack", ack, 1);
        end
        bus_stop();
        chk(n_stb == exp_n + 5, "R6 burst count", n_stb - exp_n, 5);
        for (int i = 0; i < 5; i++) begin
            logic [7:0] ea;
            ea = 8'hFD + 8'(i);
            chk(log_a[(exp_n + i) % 64] == ea && log_d[(exp_n + i) % 64] == 8'h30 + 8'(i),
                "R6 burst address", log_a[(exp_n + i) % 64], ea);
        end

        // R7 read frame
        begin
            int rd0, oe0;
            exp_n = n_stb;
            rd0 = n_rd;
            bus_start(); send_byte(8'h5D, ack);
            chk(ack, "R7 read ack", ack, 1);
            chk(n_rd == rd0 + 1, "R7 rd_req pulse", n_rd - rd0, 1);
            w(4);
            oe0 = n_oe;
            send_byte(8'hFF, ack);
            send_byte(8'hFF, ack);
            bus_stop();
            chk(n_oe == oe0, "R7 no drive after read ack", n_oe - oe0, 0);
            chk(n_stb == exp_n, "R7 no write", n_stb, exp_n);
        end

        // R8 repeated START between frames and in mid data byte
        exp_n = n_stb;
        bus_start(); send_byte(8'h5C, ack); send_byte(8'h10, ack); send_byte(8'h11, ack);
        bus_start(); send_byte(8'h5C, ack); send_byte(8'h50, ack); send_bits(8'hC3, 4);
        bus_start(); send_byte(8'h5C, ack);
        chk(ack, "R8 device ack after repeated start", ack, 1);
        send_byte(8'h40, ack); send_byte(8'h22, ack);
        bus_stop();
        chk(n_stb == exp_n + 2, "R8 strobe count", n_stb - exp_n, 2);
        chk(log_a[exp_n % 64] == 8'h10 && log_d[exp_n % 64] == 8'h11,
            "R8 first frame write", log_a[exp_n % 64], 8'h10);
        chk(log_a[(exp_n + 1) % 64] == 8'h40 && log_d[(exp_n + 1) % 64] == 8'h22,
            "R8 new frame write", log_a[(exp_n + 1) % 64], 8'h40);

        // R9 bytes after STOP without START
        exp_n = n_stb;
        bus_start(); send_byte(8'h5C, ack); send_byte(8'h20, ack); bus_stop();
        scl_m = 1'b0; w(Q);
        send_byte(8'h5C, ack);
        chk(!ack, "R9 no ack after stop", ack, 0);
        send_byte(8'h21, ack);
        chk(!ack, "R9 data ignored after stop", ack, 0);
        bus_stop();
        chk(n_stb == exp_n, "R9 no write after stop", n_stb, exp_n);
        chk(!sda_oe, "R10 released when idle", sda_oe, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule